// File: doc/BRIEF.md
# Voltage Request Register Interface

This block is the software-facing side of a voltage set-point update engine. A capture stage elsewhere on the chip reports, per channel, that a new target voltage has been chosen: a one-cycle event strobe plus the set-point value. The block keeps a pending flag and a latched set point for every channel. It presents them to an external microcontroller through a byte-wide, single-beat bus slave register file and an interrupt line.

Firmware takes ownership of a channel by setting that channel's in-process bit. This freezes the channel's latched set point against newer events. It also routes that channel's target slave address and set point into a pair of shared read windows. When the transfer to the regulator is finished, firmware records the outcome in the status register. It then releases the in-process bit. If the success flag is set at the moment of release, the pending request is retired. A status bit also drives the regulators' write-protect pin directly.

Top module: `vreq_regif`

## Requirements
- R1: After reset, ack, err, irq_o and wp_o are low, and every pending, in-process, status and enable bit reads zero.
- R2: A bus access (cyc and stb high) to a defined offset is answered by ack exactly one cycle later, for exactly one cycle.
- R3: An access to any offset above 0x18 is answered by err instead of ack one cycle later, and it changes no state.
- R4: Offsets 0x00–0x0F return channel identity: bits 2:0 hold the device number, bits 5:3 the trim-channel number, bits 7:6 zero. With default parameters, channel c has device c mod 8 and trim channel (c/2) mod 8. These registers ignore writes, and channels at or above NCH read zero.
- R5: An event on channel c sets pending bit c, which reads at offset 0x10 (channels 7:0) and 0x11 (channels 15:8). Writes to these offsets are ignored.
- R6: Offsets 0x12 (channels 7:0) and 0x13 (channels 15:8) hold the in-process bits and are read/write. An event on a channel whose in-process bit is set changes neither its pending bit nor its set point.
- R7: Offset 0x14 returns the 7-bit slave address of the device of the lowest-numbered in-process channel, with bit 7 zero. It returns 0 when no channel is in process. By default, device d has address 0x40 + 3d.
- R8: Offsets 0x15 and 0x16 return the latched 13-bit set point of the same selected channel: bits 7:0, then bits 12:8 in bits 4:0 with bits 7:5 zero.
- R9: Offset 0x17 is status. Bits 3:0 are read/write, and bit 0 drives wp_o (bit 1 success, bit 2 failure, bit 3 no-acknowledge). Bit 4 reads the db_busy input and ignores writes. Bits 7:5 read zero.
- R10: Clearing an in-process bit that was set retires that channel's pending bit only if status bit 1 is set at that write. Otherwise the request stays pending.
- R11: Offset 0x18 bit 0 is the interrupt enable (read/write). irq_o is high exactly when the enable is set and at least one pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_adr | input | ADR_W | Register offset |
| bus_wdat | input | 8 | Write data |
| bus_rdat | output | 8 | Read data, valid with ack |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_err | output | 1 | One-cycle error response |
| req_evt | input | NCH | Per-channel one-cycle request event |
| req_val | input | NCH*SETPT_W | Per-channel set point, sampled with its event |
| db_busy | input | 1 | Dual-boot busy flag, shown in status |
| wp_o | output | 1 | Write-protect drive |
| irq_o | output | 1 | Interrupt request |

## Verification
The properties assume that the master holds cyc and stb steady until it sees a response. They also assume the master does not start a new access in the cycle that the response appears. The bench driver drops the strobe at the response and idles one cycle before the next access. Event strobes last one cycle and are driven between bus accesses, so a lock write and an event for the same channel never land on the same edge. Reset is held for several cycles, so every history term the properties read comes from reset values.

// File: rtl/vreq_pkg.sv
package vreq_pkg;
   localparam int MAX_CH = 16;
   localparam int N_DEV  = 8;

   localparam int OFS_REQ_LO = 'h10;
   localparam int OFS_REQ_HI = 'h11;
   localparam int OFS_IP_LO  = 'h12;
   localparam int OFS_IP_HI  = 'h13;
   localparam int OFS_SADDR  = 'h14;
   localparam int OFS_SP_LO  = 'h15;
   localparam int OFS_SP_HI  = 'h16;
   localparam int OFS_STAT   = 'h17;
   localparam int OFS_IEN    = 'h18;
   localparam int OFS_LAST   = OFS_IEN;

   typedef logic [MAX_CH-1:0][2:0] id_map_t;
   typedef logic [N_DEV-1:0][6:0]  dev_addr_t;

   function automatic id_map_t dflt_dev();
      id_map_t m;
      for (int i = 0; i < MAX_CH; i++) m[i] = 3'(i % 8);
      return m;
   endfunction

   function automatic id_map_t dflt_trim();
      id_map_t m;
      for (int i = 0; i < MAX_CH; i++) m[i] = 3'((i / 2) % 8);
      return m;
   endfunction

   function automatic dev_addr_t dflt_addr();
      dev_addr_t m;
      for (int i = 0; i < N_DEV; i++) m[i] = 7'(64 + 3 * i);
      return m;
   endfunction
endpackage

// File: rtl/vreq_bus.sv
module vreq_bus #(
   parameter int ADR_W    = 8,
   parameter int TOP_OFS  = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc,
   input  logic             stb,
   input  logic [ADR_W-1:0] adr,
   output logic             go,
   output logic             hit,
   output logic             ack,
   output logic             err
);
   assign go  = cyc & stb & ~ack & ~err;
   assign hit = (adr <= ADR_W'(TOP_OFS));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack <= 1'b0;
         err <= 1'b0;
      end else begin
         ack <= go & hit;
         err <= go & ~hit;
      end
   end
endmodule

// File: rtl/vreq_pick.sv
module vreq_pick #(
   parameter int NCH  = 16,
   parameter int CH_W = 4
) (
   input  logic [NCH-1:0]  req,
   output logic [CH_W-1:0] idx,
   output logic            vld
);
   always_comb begin
      idx = '0;
      vld = 1'b0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx = CH_W'(i);
            vld = 1'b1;
         end
      end
   end
endmodule

// File: rtl/vreq_chan_store.sv
module vreq_chan_store #(
   parameter int NCH     = 16,
   parameter int SETPT_W = 13
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NCH-1:0]         evt,
   input  logic [NCH*SETPT_W-1:0] val_in,
   input  logic [NCH-1:0]         lock,
   input  logic [NCH-1:0]         retire,
   output logic [NCH-1:0]         pend,
   output logic [NCH*SETPT_W-1:0] val_q
);
   for (genvar g = 0; g < NCH; g++) begin : g_ch
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend[g]                       <= 1'b0;
            val_q[g*SETPT_W +: SETPT_W]   <= '0;
         end else if (evt[g] && !lock[g]) begin
            pend[g]                       <= 1'b1;
            val_q[g*SETPT_W +: SETPT_W]   <= val_in[g*SETPT_W +: SETPT_W];
         end else if (retire[g]) begin
            pend[g]                       <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/vreq_regif.sv
module vreq_regif
   import vreq_pkg::*;
#(
   parameter int        NCH      = 16,
   parameter int        SETPT_W  = 13,
   parameter int        ADR_W    = 8,
   parameter id_map_t   CH_DEV   = dflt_dev(),
   parameter id_map_t   CH_TRIM  = dflt_trim(),
   parameter dev_addr_t DEV_ADDR = dflt_addr()
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_cyc,
   input  logic                   bus_stb,
   input  logic                   bus_we,
   input  logic [ADR_W-1:0]       bus_adr,
   input  logic [7:0]             bus_wdat,
   output logic [7:0]             bus_rdat,
   output logic                   bus_ack,
   output logic                   bus_err,
   input  logic [NCH-1:0]         req_evt,
   input  logic [NCH*SETPT_W-1:0] req_val,
   input  logic                   db_busy,
   output logic                   wp_o,
   output logic                   irq_o
);
   localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

   if (NCH < 1 || NCH > MAX_CH) begin : g_bad_nch
      $error("vreq_regif: NCH must be 1..16");
   end
   if (SETPT_W < 9 || SETPT_W > 16) begin : g_bad_sp
      $error("vreq_regif: SETPT_W must be 9..16");
   end
   if (ADR_W < 5 || ADR_W > 16) begin : g_bad_adr
      $error("vreq_regif: ADR_W must be 5..16");
   end

   logic                   go, hit, wr;
   logic [NCH-1:0]         pend, inproc, ip_nx, retire;
   logic [NCH*SETPT_W-1:0] setpt;
   logic [CH_W-1:0]        sel_idx;
   logic                   sel_vld;
   logic [3:0]             stat;
   logic                   ien;
   logic [15:0]            ip16, ip16_nx, pend16, sp16;
   logic [7:0]             rd_mux, saddr;
   int                     a;

   vreq_bus #(.ADR_W(ADR_W), .TOP_OFS(OFS_LAST)) u_bus (
      .clk(clk), .rst_n(rst_n), .cyc(bus_cyc), .stb(bus_stb), .adr(bus_adr),
      .go(go), .hit(hit), .ack(bus_ack), .err(bus_err)
   );

   vreq_chan_store #(.NCH(NCH), .SETPT_W(SETPT_W)) u_store (
      .clk(clk), .rst_n(rst_n), .evt(req_evt), .val_in(req_val),
      .lock(inproc), .retire(retire), .pend(pend), .val_q(setpt)
   );

   vreq_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
      .req(inproc), .idx(sel_idx), .vld(sel_vld)
   );

   assign a      = int'(bus_adr);
   assign wr     = go & hit & bus_we;
   assign ip16   = 16'(inproc);
   assign pend16 = 16'(pend);

   always_comb begin
      ip16_nx = ip16;
      if (wr && a == OFS_IP_LO) ip16_nx[7:0]  = bus_wdat;
      if (wr && a == OFS_IP_HI) ip16_nx[15:8] = bus_wdat;
      ip_nx  = ip16_nx[NCH-1:0];
      retire = stat[1] ? (inproc & ~ip_nx) : '0;
   end

   always_comb begin
      saddr = sel_vld ? {1'b0, DEV_ADDR[CH_DEV[4'(sel_idx)]]} : 8'h00;
      sp16  = sel_vld ? 16'(setpt[int'(sel_idx)*SETPT_W +: SETPT_W]) : 16'h0000;
   end

   always_comb begin
      rd_mux = 8'h00;
      if (a < MAX_CH) begin
         if (a < NCH) rd_mux = {2'b00, CH_TRIM[bus_adr[3:0]], CH_DEV[bus_adr[3:0]]};
      end else begin
         case (a)
            OFS_REQ_LO: rd_mux = pend16[7:0];
            OFS_REQ_HI: rd_mux = pend16[15:8];
            OFS_IP_LO:  rd_mux = ip16[7:0];
            OFS_IP_HI:  rd_mux = ip16[15:8];
            OFS_SADDR:  rd_mux = saddr;
            OFS_SP_LO:  rd_mux = sp16[7:0];
            OFS_SP_HI:  rd_mux = sp16[15:8];
            OFS_STAT:   rd_mux = {3'b000, db_busy, stat};
            OFS_IEN:    rd_mux = {7'b0, ien};
            default:    rd_mux = 8'h00;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inproc   <= '0;
         stat     <= '0;
         ien      <= 1'b0;
         bus_rdat <= '0;
      end else begin
         inproc <= ip_nx;
         if (wr && a == OFS_STAT) stat <= bus_wdat[3:0];
         if (wr && a == OFS_IEN)  ien  <= bus_wdat[0];
         if (go) bus_rdat <= rd_mux;
      end
   end

   assign wp_o  = stat[0];
   assign irq_o = ien & (|pend);
endmodule

// File: rtl/vreq_regif_chk.sv
module vreq_regif_chk #(
   parameter int NCH   = 16,
   parameter int ADR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cyc,
   input logic             stb,
   input logic             we,
   input logic [ADR_W-1:0] adr,
   input logic             ack,
   input logic             err,
   input logic             irq,
   input logic             wp,
   input logic [NCH-1:0]   pend,
   input logic [NCH-1:0]   inproc
);
   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack); // R2
   AST_RESP_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (ack || err) |-> $past(cyc && stb)); // R2
   AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack && err)); // R3
   AST_ERR_BAD_ADR: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> ($past(adr) > ADR_W'(vreq_pkg::OFS_LAST))); // R3
   AST_LOCK_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & ~$past(pend) & $past(inproc)) == '0); // R6
   AST_WP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cyc && stb && we && !ack && !err && adr == ADR_W'(vreq_pkg::OFS_STAT))
      |-> $stable(wp)); // R9
   AST_RETIRE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(pend) & ~pend) != '0) |-> $past(cyc && stb && we)); // R10
   AST_IRQ_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (pend != '0)); // R11
endmodule

bind vreq_regif vreq_regif_chk #(.NCH(NCH), .ADR_W(ADR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cyc(bus_cyc), .stb(bus_stb), .we(bus_we),
   .adr(bus_adr), .ack(bus_ack), .err(bus_err), .irq(irq_o), .wp(wp_o),
   .pend(pend), .inproc(inproc)
);

// File: tb/vreq_regif_test.sv
module vreq_regif_test;
   localparam int PERIOD = 10;
   localparam int NCH = 16;
   localparam int SW  = 13;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cyc = 0, stb = 0, we = 0, db_busy = 0;
   logic [7:0] adr = '0, wdat = '0;
   logic [7:0] rdat;
   logic ack, err, wp_o, irq_o;
   logic [NCH-1:0] evt = '0;
   logic [NCH*SW-1:0] rv = '0;

   int tests = 0, fails = 0;

   typedef struct {
      logic [7:0] d;
      bit         chk_d;
      bit         is_err;
      string      tag;
   } exp_t;
   exp_t q[$];

   always #(PERIOD/2) clk = ~clk;

   vreq_regif uut (
      .clk(clk), .rst_n(rst_n), .bus_cyc(cyc), .bus_stb(stb), .bus_we(we),
      .bus_adr(adr), .bus_wdat(wdat), .bus_rdat(rdat), .bus_ack(ack), .bus_err(err),
      .req_evt(evt), .req_val(rv), .db_busy(db_busy), .wp_o(wp_o), .irq_o(irq_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, expv);
      end
   endtask

   function automatic logic [7:0] info_of(int c);
      return 8'((((c / 2) % 8) << 3) | (c % 8));
   endfunction

   function automatic logic [7:0] addr_of_ch(int c);
      return 8'(64 + 3 * (c % 8));
   endfunction

   task automatic xfer(input bit w, input int ofs, input logic [7:0] wd,
                       input logic [7:0] ed, input bit chk_d, input bit eerr,
                       input string tag);
      exp_t e;
      int n;
      e.d = ed; e.chk_d = chk_d; e.is_err = eerr; e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      cyc = 1; stb = 1; we = w; adr = 8'(ofs); wdat = wd;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!(ack || err) && n < 20);
      check(n == 1, "R2 response latency", n, 1);
      cyc = 0; stb = 0; we = 0;
      @(negedge clk);
      check(!ack && !err, "R2 response lasts one cycle", {ack, err}, 0);
   endtask

   task automatic rd(input int ofs, input logic [7:0] ed, input string tag);
      xfer(1'b0, ofs, 8'h00, ed, 1'b1, 1'b0, tag);
   endtask

   task automatic wr(input int ofs, input logic [7:0] d, input string tag);
      xfer(1'b1, ofs, d, 8'h00, 1'b0, 1'b0, tag);
   endtask

   task automatic fire(input int ch, input logic [SW-1:0] v);
      @(negedge clk);
      evt[ch] = 1'b1;
      rv[ch*SW +: SW] = v;
      @(negedge clk);
      evt = '0;
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && (ack || err)) begin
            if (q.size() == 0) begin
               check(1'b0, "R2 response without request", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(err == e.is_err, {e.tag, " response kind"}, err, e.is_err);
               if (e.chk_d && !err) check(rdat == e.d, e.tag, rdat, e.d);
            end
         end
      end
   end

   initial begin
      #(PERIOD * 100000);
      fails++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!ack && !err && !irq_o && !wp_o, "R1 outputs after reset",
            {ack, err, irq_o, wp_o}, 0);
      rd('h10, 8'h00, "R1 pending low");
      rd('h11, 8'h00, "R1 pending high");
      rd('h12, 8'h00, "R1 in-process low");
      rd('h17, 8'h00, "R1 status");
      rd('h18, 8'h00, "R1 irq enable");
      rd('h14, 8'h00, "R7 no channel selected");

      // channel identity
      rd('h00, info_of(0), "R4 info ch0");
      rd('h05, info_of(5), "R4 info ch5");
      rd('h0F, info_of(15), "R4 info ch15");
      wr('h03, 8'hFF, "R4 write to info");
      rd('h03, info_of(3), "R4 info ignores write");

      // undefined offsets
      xfer(1'b0, 'h19, 8'h00, 8'h00, 1'b0, 1'b1, "R3 read 0x19");
      xfer(1'b1, 'h20, 8'h01, 8'h00, 1'b0, 1'b1, "R3 write 0x20");
      xfer(1'b1, 'hFF, 8'h01, 8'h00, 1'b0, 1'b1, "R3 write 0xFF");
      rd('h18, 8'h00, "R3 bad write left enable alone");

      // request events
      fire(3, 13'h1ABC);
      fire(9, 13'h0123);
      rd('h10, 8'h08, "R5 pending low");
      rd('h11, 8'h02, "R5 pending high");
      wr('h10, 8'hFF, "R5 write to pending");
      rd('h10, 8'h08, "R5 pending ignores write");
      @(negedge clk);
      check(!irq_o, "R11 irq masked", irq_o, 0);
      wr('h18, 8'h01, "R11 enable irq");
      rd('h18, 8'h01, "R11 enable readback");
      @(negedge clk);
      check(irq_o, "R11 irq with pending", irq_o, 1);

      // lock channel 3
      wr('h12, 8'h08, "R6 lock ch3");
      rd('h12, 8'h08, "R6 in-process readback");
      rd('h14, addr_of_ch(3), "R7 address of ch3");
      rd('h15, 8'hBC, "R8 set point low ch3");
      rd('h16, 8'h1A, "R8 set point high ch3");
      fire(3, 13'h0555);
      rd('h15, 8'hBC, "R6 locked set point kept");
      wr('h13, 8'h02, "R6 lock ch9");
      rd('h13, 8'h02, "R6 in-process high readback");
      rd('h14, addr_of_ch(3), "R7 lowest in-process wins");

      // status
      db_busy = 1'b1;
      wr('h17, 8'hFF, "R9 status write");
      rd('h17, 8'h1F, "R9 status readback");
      @(negedge clk);
      check(wp_o, "R9 wp_o follows bit 0", wp_o, 1);
      wr('h17, 8'h00, "R9 status clear");
      rd('h17, 8'h10, "R9 busy bit read-only");
      @(negedge clk);
      check(!wp_o, "R9 wp_o released", wp_o, 0);
      db_busy = 1'b0;

      // release without success flag
      wr('h12, 8'h00, "R10 release ch3 no success");
      rd('h10, 8'h08, "R10 request kept");
      wr('h12, 8'h08, "R10 relock ch3");
      wr('h17, 8'h02, "R10 set success");
      wr('h12, 8'h00, "R10 release ch3 with success");
      rd('h10, 8'h00, "R10 ch3 retired");
      rd('h14, addr_of_ch(9), "R7 selection moves to ch9");
      rd('h15, 8'h23, "R8 set point low ch9");
      rd('h16, 8'h01, "R8 set point high ch9");
      wr('h13, 8'h00, "R10 release ch9 with success");
      rd('h11, 8'h00, "R10 ch9 retired");
      @(negedge clk);
      check(!irq_o, "R11 irq drops with no pending", irq_o, 0);
      rd('h14, 8'h00, "R7 none selected again");
      rd('h16, 8'h00, "R8 none selected reads zero");

      repeat (3) @(negedge clk);
      check(q.size() == 0, "R2 all responses seen", q.size(), 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule